// File: doc/BRIEF.md
# Event-Triggered UART Action Unit

This block pairs a free-running timer with a one-shot dispatcher. It starts the timing-critical steps of a serial link by hardware. Software writes a command that names a trigger and a reaction. The trigger is one of: none, a detected start bit, a completed reception, or the timer reaching a programmed value. The reaction is one of: capture the timer, clear the timer, launch a transmission, switch the receiver on, or switch the receiver off. When the trigger is seen, the reaction fires as a single-cycle strobe one clock later. The strobe does not depend on software service time. The command can also ask for an interrupt strobe in place of the reaction.

One register holds either the programmed match value or the last captured timestamp. Software writes it directly, and a capture reaction overwrites it. A command whose trigger and reaction do not form a permitted pair is dropped. It raises an error flag and leaves the unit idle.

Top module: `evt_action_unit`

## Requirements
- R1: While reset is held, the timer, the reference register, the error flag, the armed flag and all six strobes read 0.
- R2: The timer advances by one each clock and wraps from all-ones to 0.
- R3: Trigger codes are 00 none, 01 start bit, 10 receive done, 11 timer match. Reaction codes are 001 capture, 010 timer clear, 011 transmit start, 100 receiver on, 101 receiver off. Trigger 00 permits 011, 100 and 101. Triggers 01 and 10 permit 001, 010 and 101. Trigger 11 permits 010, 011, 100 and 101. A command with any other pair sets cmd_err, leaves armed low and produces no strobe. A permitted command clears cmd_err and sets armed in the cycle after the write.
- R4: For trigger 00, the strobe is high during the second cycle after the write cycle.
- R5: For triggers 01 and 10, the strobe is high during the cycle after the cycle in which the event input is high.
- R6: For trigger 11, the strobe is high during the cycle after the cycle in which the timer equals the reference register.
- R7: A capture reaction loads the timer value of the trigger cycle into the reference register, visible together with stamp_p.
- R8: A timer-clear reaction makes the timer read 0 during the tclr_p cycle.
- R9: With cmd_irq set at the write, irq pulses in place of the reaction strobe, with the same timing.
- R10: After a strobe fires, armed is low and further events cause no strobe until a new command is written.
- R11: Each fired command gives exactly one strobe, one cycle wide, and at most one strobe is high in any cycle.
- R12: A write on ref_wr is visible on ref_q in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_event | input | 2 | Trigger select |
| cmd_action | input | 3 | Reaction select |
| cmd_irq | input | 1 | Interrupt instead of reaction |
| ref_wr | input | 1 | Reference register write strobe |
| ref_wdata | input | TW | Reference register write data |
| sof_det | input | 1 | Start-bit detected pulse from receiver |
| rx_done | input | 1 | Receive-complete pulse from receiver |
| timer_q | output | TW | Free-running timer value |
| ref_q | output | TW | Match value or captured timestamp |
| cmd_err | output | 1 | Last command was a forbidden pair |
| armed | output | 1 | A command is waiting for its trigger |
| stamp_p | output | 1 | Capture strobe |
| tclr_p | output | 1 | Timer-clear strobe |
| tx_go | output | 1 | Transmit start strobe |
| rx_on | output | 1 | Receiver enable strobe |
| rx_off | output | 1 | Receiver disable strobe |
| irq | output | 1 | Interrupt strobe |

## Verification
The bench builds the unit with an 8-bit timer, TW = 8. At that width the wrap from all-ones to zero comes within a few hundred cycles, and match targets a few counts ahead of the running timer stay short. Every command the bench writes runs through the same trigger-and-observe routine. That routine checks which strobe fires, the exact cycle it fires in, and the timer or reference value beside it. This covers permitted and forbidden pairs, interrupt substitution, and re-triggering after the one-shot has fired.

// File: rtl/eau_pkg.sv
package eau_pkg;
  typedef logic [1:0] ev_sel_t;
  typedef logic [2:0] act_sel_t;

  localparam ev_sel_t  EV_NONE   = 2'b00;
  localparam ev_sel_t  EV_SOF    = 2'b01;
  localparam ev_sel_t  EV_RXDONE = 2'b10;
  localparam ev_sel_t  EV_MATCH  = 2'b11;

  localparam act_sel_t AC_STAMP  = 3'd1;
  localparam act_sel_t AC_TCLR   = 3'd2;
  localparam act_sel_t AC_TXGO   = 3'd3;
  localparam act_sel_t AC_RXON   = 3'd4;
  localparam act_sel_t AC_RXOFF  = 3'd5;

  // strobe vector: bit 0 = interrupt, bit k = reaction code k
  localparam int ACT_LAST = 5;

  function automatic logic pair_ok(input ev_sel_t ev, input act_sel_t ac);
    logic ok;
    case (ev)
      EV_NONE:          ok = (ac == AC_TXGO) || (ac == AC_RXON) || (ac == AC_RXOFF);
      EV_SOF, EV_RXDONE: ok = (ac == AC_STAMP) || (ac == AC_TCLR) || (ac == AC_RXOFF);
      default:          ok = (ac == AC_TCLR) || (ac == AC_TXGO) || (ac == AC_RXON) || (ac == AC_RXOFF);
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/eau_timer.sv
module eau_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [TW-1:0] count_q
);
  localparam logic [TW-1:0] ONE = TW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else          count_q <= count_q + ONE;
  end
endmodule

// File: rtl/eau_cmd.sv
module eau_cmd
  import eau_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_wr,
  input  ev_sel_t  ev_in,
  input  act_sel_t ac_in,
  input  logic     irq_in,
  input  logic     fire,
  output ev_sel_t  ev_q,
  output act_sel_t ac_q,
  output logic     irq_q,
  output logic     armed_q,
  output logic     err_q
);
  logic legal;
  assign legal = pair_ok(ev_in, ac_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q    <= EV_NONE;
      ac_q    <= '0;
      irq_q   <= 1'b0;
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (cmd_wr) begin
      ev_q    <= ev_in;
      ac_q    <= ac_in;
      irq_q   <= irq_in;
      armed_q <= legal;
      err_q   <= !legal;
    end else if (fire) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/eau_dispatch.sv
module eau_dispatch
  import eau_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed,
  input  logic            cmd_wr,
  input  ev_sel_t         ev_q,
  input  act_sel_t        ac_q,
  input  logic            irq_q,
  input  logic            sof_det,
  input  logic            rx_done,
  input  logic [TW-1:0]   timer,
  input  logic [TW-1:0]   refv,
  output logic            hit,
  output logic            fire,
  output logic            do_clr,
  output logic            do_stamp,
  output logic [ACT_LAST:0] pulse_q
);
  always_comb begin
    case (ev_q)
      EV_NONE:   hit = 1'b1;
      EV_SOF:    hit = sof_det;
      EV_RXDONE: hit = rx_done;
      default:   hit = (timer == refv);
    endcase
  end

  // a command write in the same cycle supersedes the pending one
  assign fire     = armed && hit && !cmd_wr;
  assign do_clr   = fire && !irq_q && (ac_q == AC_TCLR);
  assign do_stamp = fire && !irq_q && (ac_q == AC_STAMP);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q[0] <= 1'b0;
    else        pulse_q[0] <= fire && irq_q;
  end

  for (genvar g = 1; g <= ACT_LAST; g++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (!rst_n) pulse_q[g] <= 1'b0;
      else        pulse_q[g] <= fire && !irq_q && (ac_q == act_sel_t'(g));
    end
  end
endmodule

// File: rtl/evt_action_unit.sv
module evt_action_unit
  import eau_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [1:0]    cmd_event,
  input  logic [2:0]    cmd_action,
  input  logic          cmd_irq,
  input  logic          ref_wr,
  input  logic [TW-1:0] ref_wdata,
  input  logic          sof_det,
  input  logic          rx_done,
  output logic [TW-1:0] timer_q,
  output logic [TW-1:0] ref_q,
  output logic          cmd_err,
  output logic          armed,
  output logic          stamp_p,
  output logic          tclr_p,
  output logic          tx_go,
  output logic          rx_on,
  output logic          rx_off,
  output logic          irq
);
  ev_sel_t  ev_q;
  act_sel_t ac_q;
  logic     irq_q;
  logic     hit, fire, do_clr, do_stamp;
  logic [ACT_LAST:0] pulse_q;

  eau_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
    .ev_in(cmd_event), .ac_in(cmd_action), .irq_in(cmd_irq),
    .fire(fire), .ev_q(ev_q), .ac_q(ac_q), .irq_q(irq_q),
    .armed_q(armed), .err_q(cmd_err)
  );

  eau_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(do_clr), .count_q(timer_q)
  );

  eau_dispatch #(.TW(TW)) u_dsp (
    .clk(clk), .rst_n(rst_n), .armed(armed), .cmd_wr(cmd_wr),
    .ev_q(ev_q), .ac_q(ac_q), .irq_q(irq_q),
    .sof_det(sof_det), .rx_done(rx_done),
    .timer(timer_q), .refv(ref_q),
    .hit(hit), .fire(fire), .do_clr(do_clr), .do_stamp(do_stamp),
    .pulse_q(pulse_q)
  );

  // capture by hardware wins over a software write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        ref_q <= '0;
    else if (do_stamp) ref_q <= timer_q;
    else if (ref_wr)   ref_q <= ref_wdata;
  end

  assign irq     = pulse_q[0];
  assign stamp_p = pulse_q[AC_STAMP];
  assign tclr_p  = pulse_q[AC_TCLR];
  assign tx_go   = pulse_q[AC_TXGO];
  assign rx_on   = pulse_q[AC_RXON];
  assign rx_off  = pulse_q[AC_RXOFF];
endmodule

// File: rtl/eau_chk.sv
module eau_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic [1:0]    cmd_event,
  input logic [2:0]    cmd_action,
  input logic          fire,
  input logic [TW-1:0] timer_q,
  input logic [TW-1:0] ref_q,
  input logic          cmd_err,
  input logic          armed,
  input logic          stamp_p,
  input logic          tclr_p,
  input logic          tx_go,
  input logic          rx_on,
  input logic          rx_off,
  input logic          irq
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stamp_p, tclr_p, tx_go, rx_on, rx_off, irq}));

  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !tclr_p |-> timer_q == TW'($past(timer_q) + TW'(1)));

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tclr_p |-> timer_q == '0);

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    seen && stamp_p |-> ref_q == $past(timer_q));

  a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !eau_pkg::pair_ok(cmd_event, cmd_action) |=> cmd_err && !armed);

  a_r10_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);

  a_r5_fire_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $countones({stamp_p, tclr_p, tx_go, rx_on, rx_off, irq}) == 1);
endmodule

bind evt_action_unit eau_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_event(cmd_event),
  .cmd_action(cmd_action), .fire(fire), .timer_q(timer_q), .ref_q(ref_q),
  .cmd_err(cmd_err), .armed(armed), .stamp_p(stamp_p), .tclr_p(tclr_p),
  .tx_go(tx_go), .rx_on(rx_on), .rx_off(rx_off), .irq(irq)
);

// File: tb/sim_evt_action_unit.sv
module sim_evt_action_unit;
  localparam int TW = 8;
  localparam int NV = 22;
  // entry: [6:5] trigger, [4:2] reaction, [1] interrupt mode, [0] expected legal (R3)
  localparam logic [6:0] VEC [NV] = '{
    7'b00_011_0_1, 7'b00_100_0_1, 7'b00_101_0_1, 7'b00_001_0_0, 7'b00_010_0_0,
    7'b01_001_0_1, 7'b01_010_0_1, 7'b01_101_0_1, 7'b01_011_0_0,
    7'b10_001_0_1, 7'b10_010_0_1, 7'b10_101_0_1, 7'b10_100_0_0,
    7'b11_010_0_1, 7'b11_011_0_1, 7'b11_100_0_1, 7'b11_101_0_1, 7'b11_001_0_0,
    7'b01_001_1_1, 7'b11_011_1_1, 7'b00_000_0_0, 7'b11_110_0_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0, cmd_irq = 1'b0, ref_wr = 1'b0, sof_det = 1'b0, rx_done = 1'b0;
  logic [1:0] cmd_event = '0;
  logic [2:0] cmd_action = '0;
  logic [TW-1:0] ref_wdata = '0;
  logic [TW-1:0] timer_q, ref_q;
  logic cmd_err, armed, stamp_p, tclr_p, tx_go, rx_on, rx_off, irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  evt_action_unit #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_event(cmd_event),
    .cmd_action(cmd_action), .cmd_irq(cmd_irq), .ref_wr(ref_wr),
    .ref_wdata(ref_wdata), .sof_det(sof_det), .rx_done(rx_done),
    .timer_q(timer_q), .ref_q(ref_q), .cmd_err(cmd_err), .armed(armed),
    .stamp_p(stamp_p), .tclr_p(tclr_p), .tx_go(tx_go), .rx_on(rx_on),
    .rx_off(rx_off), .irq(irq)
  );

  function automatic logic [5:0] strobes();
    return {rx_off, rx_on, tx_go, tclr_p, stamp_p, irq};
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic run_vec(input logic [1:0] ev, input logic [2:0] ac,
                         input logic iq, input logic legal);
    logic [TW-1:0] refv = '0;
    logic [TW-1:0] prev_t;
    logic [5:0] exp_p, obs;
    logic got = 1'b0;
    string req;
    exp_p = iq ? 6'd1 : (6'd1 << ac);
    req = iq ? "R9" : (ev == 2'b00) ? "R4" : (ev == 2'b11) ? "R6" : "R5";
    cmd_wr = 1'b1; cmd_event = ev; cmd_action = ac; cmd_irq = iq;
    if (ev == 2'b11) begin
      refv = timer_q + TW'(4);
      ref_wr = 1'b1; ref_wdata = refv;
    end
    @(negedge clk);
    cmd_wr = 1'b0; ref_wr = 1'b0;
    chk(cmd_err == !legal, "R3", "cmd_err after write", int'(cmd_err), int'(!legal));
    chk(armed == legal, "R3", "armed after write", int'(armed), int'(legal));
    if (ev == 2'b11) chk(ref_q == refv, "R12", "ref write", int'(ref_q), int'(refv));
    prev_t = timer_q;
    sof_det = (ev == 2'b01);
    rx_done = (ev == 2'b10);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      sof_det = 1'b0; rx_done = 1'b0;
      obs = strobes();
      if (obs != 6'd0) begin
        if (got) chk(1'b0, "R11", "second strobe", int'(obs), 0);
        else begin
          got = 1'b1;
          chk(obs == exp_p, req, "strobe pattern", int'(obs), int'(exp_p));
          if (ev != 2'b11) chk(k == 0, req, "latency", k, 0);
          else chk(prev_t == refv, "R6", "timer before strobe", int'(prev_t), int'(refv));
          if (!iq && ac == 3'd1) chk(ref_q == prev_t, "R7", "captured value", int'(ref_q), int'(prev_t));
          if (!iq && ac == 3'd2) chk(timer_q == '0, "R8", "timer after clear", int'(timer_q), 0);
        end
      end
      prev_t = timer_q;
    end
    if (legal) chk(got, req, "strobe fired", int'(got), 1);
    else       chk(!got, "R3", "forbidden pair stays quiet", int'(got), 0);
    chk(!armed, "R10", "disarmed after run", int'(armed), 0);
    sof_det = 1'b1; rx_done = 1'b1;
    @(negedge clk);
    sof_det = 1'b0; rx_done = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(strobes() == 6'd0, "R10", "re-trigger ignored", int'(strobes()), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [TW-1:0] t0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(timer_q == '0 && ref_q == '0, "R1", "timer/ref in reset", int'(timer_q), 0);
    chk(!cmd_err && !armed, "R1", "flags in reset", int'({cmd_err, armed}), 0);
    chk(strobes() == 6'd0, "R1", "strobes in reset", int'(strobes()), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: counting
    t0 = timer_q;
    @(negedge clk);
    chk(timer_q == t0 + TW'(1), "R2", "increment", int'(timer_q), int'(t0 + TW'(1)));
    // R12: plain reference write
    ref_wr = 1'b1; ref_wdata = TW'(8'hA5);
    @(negedge clk);
    ref_wr = 1'b0;
    chk(ref_q == TW'(8'hA5), "R12", "ref load", int'(ref_q), 'hA5);
    // table walk
    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i][6:5], VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end
    // R3: a legal write after a forbidden one clears the error
    run_vec(2'b00, 3'b000, 1'b0, 1'b0);
    run_vec(2'b00, 3'b101, 1'b0, 1'b1);
    chk(!cmd_err, "R3", "error cleared", int'(cmd_err), 0);
    // R2: wrap from all-ones to zero
    for (int k = 0; k < 600 && timer_q != '1; k++) @(negedge clk);
    chk(timer_q == '1, "R2", "reached all-ones", int'(timer_q), int'({TW{1'b1}}));
    @(negedge clk);
    chk(timer_q == '0, "R2", "wrap", int'(timer_q), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule